// File: doc/BRIEF.md
# Add/Subtract Running-Sum Accumulator

This block keeps a wide running total and updates it on every clock edge. An 8-bit unsigned operand is either added to the total or taken away from it, and a single direction bit makes the choice. The total is registered and driven straight onto the output, so a result appears one cycle after its operand.

A small controller sequences the datapath. After reset, and after every synchronous clear, it passes through a one-cycle initialization state. In that state the total is forced to zero and the operand is ignored. The controller then moves to the run state and accumulates on every cycle. Arithmetic wraps modulo 2^32, and there is no overflow or underflow indication.

Top module: `addsub_accum`

## Requirements
- R1: While `rst_n` is low, `sum` is 0. The first clock edge after `rst_n` rises is an initialization cycle: `sum` stays 0 whatever `operand` and `dir` are.
- R2: In the run state with `clr` = 0 and `dir` = 1, the next edge sets `sum` to the old `sum` plus `operand`.
- R3: In the run state with `clr` = 0 and `dir` = 0, the next edge sets `sum` to the old `sum` minus `operand`.
- R4: An edge with `clr` = 1 sets `sum` to 0 in any state, whatever `dir` and `operand` are.
- R5: The edge that follows a `clr` edge is an initialization cycle when `clr` is 0 at that edge. At that edge `sum` stays 0 and the operand is ignored. Accumulation resumes on the edge after it.
- R6: `sum` wraps modulo 2^32. Subtracting 1 from 0 gives 0xFFFFFFFF, and adding 1 to 0xFFFFFFFF gives 0.
- R7: `operand` is treated as unsigned and zero-extended. Adding 0xFF raises `sum` by 255.
- R8: `sum` changes only at a rising clock edge. A change on `operand`, `dir` or `clr` between edges leaves `sum` as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the total |
| dir | input | 1 | 1 = add operand, 0 = subtract operand |
| operand | input | 8 | Unsigned value applied this cycle |
| sum | output | 32 | Registered running total |

## Verification
The directed cases look at the edges of the controller first. A design without the initialization cycle, or one that accumulates during it, would show a nonzero total right after reset or right after a clear. A clear applied together with an add would expose a design that lets accumulation win over the clear. A design that sign-extends the operand would lower the total when 0xFF is added, and a design that saturates would fail to wrap at zero and at 0xFFFFFFFF. Random runs then mix add, subtract and occasional back-to-back clears against a bench model, and each step checks that the output does not move before the edge.

// File: rtl/addsub_accum.sv
module addsub_accum #(
  parameter int OP_W  = 8,
  parameter int SUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dir,
  input  logic [OP_W-1:0]  operand,
  output logic [SUM_W-1:0] sum
);

  localparam int PAD_W = SUM_W - OP_W;

  typedef enum logic {ST_INIT = 1'b0, ST_RUN = 1'b1} phase_t;

  phase_t            phase_q;
  logic [SUM_W-1:0]  acc_q;
  logic [SUM_W-1:0]  wide_op;
  logic [SUM_W-1:0]  next_acc;

  assign wide_op  = {{PAD_W{1'b0}}, operand};
  assign next_acc = dir ? acc_q + wide_op : acc_q - wide_op;
  assign sum      = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= ST_INIT;
    else if (clr)             phase_q <= ST_INIT;
    else                      phase_q <= ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  acc_q <= '0;
    else if (clr)                acc_q <= '0;
    else if (phase_q == ST_INIT) acc_q <= '0;
    else                         acc_q <= next_acc;
  end

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum == '0));

  // R5
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_INIT) |=> (sum == '0));

  // R5
  clr_to_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase_q == ST_INIT));

  // R2
  add_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_RUN && !clr && dir) |=>
      (sum - $past(sum) == {{PAD_W{1'b0}}, $past(operand)}));

  // R3
  sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_RUN && !clr && !dir) |=>
      ($past(sum) - sum == {{PAD_W{1'b0}}, $past(operand)}));

  // R1
  always_comb begin
    if (!rst_n) reset_zero_chk: assert (acc_q == '0);
  end

endmodule

// File: tb/tb_addsub_accum.sv
module tb_addsub_accum;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        dir = 1'b0;
  logic [7:0]  operand = '0;
  logic [31:0] sum;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_sum = '0;
  bit          exp_init = 1'b1;

  addsub_accum dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .dir(dir),
    .operand(operand), .sum(sum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_next(logic [31:0] s, bit in_init,
                                             bit c, bit d, logic [7:0] op);
    if (c || in_init) return 32'd0;
    return d ? s + {24'd0, op} : s - {24'd0, op};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sum=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string req, bit c, bit d, logic [7:0] op);
    logic [31:0] held;
    held = sum;
    clr = c; dir = d; operand = op;
    #1;
    check("R8", sum, held);
    @(posedge clk);
    exp_sum  = model_next(exp_sum, exp_init, c, d, op);
    exp_init = c;
    @(negedge clk);
    check(req, sum, exp_sum);
  endtask

  initial begin
    void'($urandom(32'd20241));
    repeat (2) @(negedge clk);
    check("R1", sum, 32'd0);
    rst_n = 1'b1;
    exp_sum = '0; exp_init = 1'b1;
    step("R1", 1'b0, 1'b1, 8'h55);
    step("R7", 1'b0, 1'b1, 8'hFF);
    step("R2", 1'b0, 1'b1, 8'h01);
    step("R3", 1'b0, 1'b0, 8'h10);
    step("R4", 1'b1, 1'b1, 8'h09);
    step("R5", 1'b0, 1'b1, 8'h05);
    step("R6", 1'b0, 1'b0, 8'h01);
    step("R6", 1'b0, 1'b1, 8'h01);
    step("R4", 1'b1, 1'b0, 8'hAA);
    step("R4", 1'b1, 1'b1, 8'hAA);
    step("R5", 1'b0, 1'b0, 8'h33);
    step("R3", 1'b0, 1'b0, 8'hFF);
    for (int i = 0; i < 400; i++) begin
      bit c;
      c = (($urandom % 16) == 0);
      step(exp_init ? "R5" : (c ? "R4" : "R2"), c, 1'($urandom), 8'($urandom));
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule